// File: doc/BRIEF.md
# Window Watchdog with Sampled Trigger

This block supervises a microcontroller through one trigger pin. A prescaler divides the system clock into a coarse watchdog cycle. All window and reset timing is counted in these cycles. After power-on the block holds its reset output low for a fixed delay. It then runs a closed window, during which the software must not trigger. After that it runs an open window, during which the software must trigger.

The trigger pin is synchronised and then sampled once per watchdog cycle. A trigger counts only when the last four samples read high, high, low, low, oldest first. A valid trigger in the open window starts a new closed window. A trigger that completes inside the closed window is a failure, and so is an open window that expires with no trigger. In both cases the reset output drops a fixed number of cycles after the latest closed-window start and stays low for the power-on delay. After that the supervision sequence starts again. Dropping the power-good input forces the block back into its power-on state.

Top module: `window_watchdog`

## Requirements
- R1: All timing advances once per watchdog cycle of CLK_DIV clocks. The prescaler restarts from zero whenever `rst_n` or `pwr_good` releases.
- R2: While `rst_n` is low, and after it releases, `wd_rst_n` is 0 and `win_state` is 0 (reset) for RST_CYC cycles.
- R3: When the reset phase ends, `wd_rst_n` rises and `win_state` becomes 1 (closed) for CW_CYC cycles.
- R4: After the closed window, `win_state` is 2 (open) for at most OW_CYC cycles.
- R5: The trigger pin is sampled once per cycle. A valid trigger is the sample sequence 1,1,0,0 (oldest first), judged at the cycle of its fourth sample. A pin that is high but not yet falling is no trigger.
- R6: A valid trigger whose fourth sample lands in the open window, including its last cycle, returns `win_state` to 1 and starts a new closed window.
- R7: A trigger whose first three samples fall in the closed window and whose fourth sample falls in the open window is valid.
- R8: A valid trigger completing in the closed window moves `win_state` to 3 (failed). Later triggers are then ignored. `wd_rst_n` falls CW_CYC+OW_CYC cycles after that closed window began.
- R9: If the open window expires with no valid trigger, `wd_rst_n` falls CW_CYC+OW_CYC cycles after the latest closed-window start.
- R10: A failure reset keeps `wd_rst_n` low for RST_CYC cycles. The block then enters the closed window as it does after power-on.
- R11: While `pwr_good` is low, `win_state` is 0 and `wd_rst_n` is 0 from the next clock on. Releasing it restarts the full power-on delay and clears the sample history.
- R12: A single high sample followed by lows is not a trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good / restart input, low forces power-on state |
| trig_in | input | 1 | Trigger pin from the supervised processor, asynchronous |
| wd_rst_n | output | 1 | Active-low reset to the supervised processor |
| win_state | output | 2 | 0 reset, 1 closed, 2 open, 3 failed awaiting reset |

## Verification
The bench builds the block with a four-clock watchdog cycle, a six-cycle reset, and four-cycle closed and open windows, instead of 100/64/32/32. A full sequence of windows therefore fits in a few dozen cycles. This makes several hard cases reachable in one run: a trigger that straddles the window boundary, a trigger on the very last open cycle, a pretrigger followed by a further ignored trigger, a window timeout and a power-good drop. The same arithmetic (closed start plus CW+OW, reset length RST_CYC) applies at the default sizes.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
  typedef enum logic [1:0] {
    WS_RESET  = 2'd0,
    WS_CLOSED = 2'd1,
    WS_OPEN   = 2'd2,
    WS_FAULT  = 2'd3
  } win_state_e;
endpackage

// File: rtl/wwdg_tick.sv
// Prescaler: one-clock tick every DIV clocks, restarted by power-good low.
module wwdg_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pre_q;
  logic [W-1:0] pre_nxt;

  always_comb begin
    tick    = pwr_good && (pre_q == LAST);
    pre_nxt = pre_q;
    if (!pwr_good) begin
      pre_nxt = '0;
    end else if (pre_q == LAST) begin
      pre_nxt = '0;
    end else begin
      pre_nxt = pre_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_nxt;
    end
  end

  generate
    if (DIV > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end
  endgenerate
endmodule

// File: rtl/wwdg_trig_dec.sv
// Synchroniser plus per-cycle sampler; flags the 1,1,0,0 sample sequence.
module wwdg_trig_dec #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic tick,
  input  logic trig_pin,
  output logic trig_valid
);
  localparam int HIST_W = 3;
  localparam logic [HIST_W:0] PATTERN = 4'b1100;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_nxt;
  logic [HIST_W-1:0]      hist_q;
  logic [HIST_W-1:0]      hist_nxt;
  logic                   pin_s;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_nxt = {sync_q[SYNC_STAGES-2:0], trig_pin};
  end

  always_comb begin
    hist_nxt = hist_q;
    if (!pwr_good) begin
      hist_nxt = '0;
    end else if (tick) begin
      hist_nxt = {hist_q[HIST_W-2:0], pin_s};
    end
  end

  // The fourth sample is judged in the cycle it is taken.
  assign trig_valid = tick && ({hist_q, pin_s} == PATTERN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      sync_q <= sync_nxt;
      hist_q <= hist_nxt;
    end
  end

  AST_HIST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !trig_valid); // R11
endmodule

// File: rtl/wwdg_seq.sv
// Window sequencer: reset phase, closed window, open window, failed wait.
module wwdg_seq
  import wwdg_pkg::*;
#(
  parameter int RST_CYC = 64,
  parameter int CW_CYC  = 32,
  parameter int OW_CYC  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       tick,
  input  logic       trig_valid,
  output win_state_e state,
  output logic       wd_rst_n
);
  localparam int FAIL_AT = CW_CYC + OW_CYC;
  localparam int CNT_MAX = (FAIL_AT > RST_CYC) ? FAIL_AT : RST_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] CW_LAST   = CW'(CW_CYC - 1);
  localparam logic [CW-1:0] FAIL_LAST = CW'(FAIL_AT - 1);

  win_state_e    state_q, state_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    if (!pwr_good) begin
      state_nxt = WS_RESET;
      cnt_nxt   = '0;
    end else if (tick) begin
      unique case (state_q)
        WS_RESET: begin
          if (cnt_q == RST_LAST) begin
            state_nxt = WS_CLOSED;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt_q + CW'(1);
          end
        end
        WS_CLOSED: begin
          cnt_nxt = cnt_q + CW'(1);
          if (trig_valid) begin
            state_nxt = WS_FAULT;
          end else if (cnt_q == CW_LAST) begin
            state_nxt = WS_OPEN;
          end
        end
        WS_OPEN: begin
          if (trig_valid) begin
            state_nxt = WS_CLOSED;
            cnt_nxt   = '0;
          end else if (cnt_q == FAIL_LAST) begin
            state_nxt = WS_RESET;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt_q + CW'(1);
          end
        end
        WS_FAULT: begin
          if (cnt_q == FAIL_LAST) begin
            state_nxt = WS_RESET;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt_q + CW'(1);
          end
        end
        default: begin
          state_nxt = WS_RESET;
          cnt_nxt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_RESET;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

  assign state    = state_q;
  assign wd_rst_n = (state_q != WS_RESET);

  AST_OPEN_AFTER_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_OPEN) && ($past(state_q) != WS_OPEN)
      |-> ($past(state_q) == WS_CLOSED) && ($past(cnt_q) == CW_LAST)); // R4
  AST_OPEN_TRIG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_OPEN) && trig_valid && pwr_good
      |=> (state_q == WS_CLOSED) && (cnt_q == '0)); // R6
  AST_FAULT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == WS_FAULT)
      |-> ($past(state_q) == WS_CLOSED) && $past(trig_valid)); // R8
  AST_FAIL_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != WS_RESET) |-> (cnt_q <= FAIL_LAST)); // R9
  AST_RESET_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_CLOSED) && ($past(state_q) == WS_RESET)
      |-> $past(cnt_q) == RST_LAST); // R10
  AST_PG_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (state_q == WS_RESET) && !wd_rst_n); // R11
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwdg_pkg::*;
#(
  parameter int CLK_DIV     = 100,
  parameter int RST_CYC     = 64,
  parameter int CW_CYC      = 32,
  parameter int OW_CYC      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       trig_in,
  output logic       wd_rst_n,
  output logic [1:0] win_state
);
  logic       tick;
  logic       trig_valid;
  win_state_e state;

  wwdg_tick #(.DIV(CLK_DIV)) tick_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .tick     (tick)
  );

  wwdg_trig_dec #(.SYNC_STAGES(SYNC_STAGES)) dec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .tick       (tick),
    .trig_pin   (trig_in),
    .trig_valid (trig_valid)
  );

  wwdg_seq #(.RST_CYC(RST_CYC), .CW_CYC(CW_CYC), .OW_CYC(OW_CYC)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .tick       (tick),
    .trig_valid (trig_valid),
    .state      (state),
    .wd_rst_n   (wd_rst_n)
  );

  assign win_state = state;
endmodule

// File: tb/window_watchdog_tb_top.sv
module window_watchdog_tb_top;
  localparam int DIV = 4;
  localparam int NV  = 32;

  logic       clk;
  logic       rst_n;
  logic       pwr_good;
  logic       trig_in;
  logic       wd_rst_n;
  logic [1:0] win_state;

  int total;
  int bad;

  window_watchdog #(
    .CLK_DIV(DIV), .RST_CYC(6), .CW_CYC(4), .OW_CYC(4), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .trig_in(trig_in),
    .wd_rst_n(wd_rst_n), .win_state(win_state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Entry: {pin, steps[3:0], state[1:0], rst_out, req[3:0]}
  // State codes: 0 reset, 1 closed, 2 open, 3 failed.
  localparam logic [11:0] VEC [0:NV-1] = '{
    {1'b0, 4'd5, 2'd0, 1'b0, 4'd1},   // R1: still in power-on delay
    {1'b0, 4'd1, 2'd1, 1'b1, 4'd3},   // R3: closed begins at 6 cycles
    {1'b0, 4'd1, 2'd1, 1'b1, 4'd3},
    {1'b1, 4'd1, 2'd1, 1'b1, 4'd3},
    {1'b1, 4'd1, 2'd1, 1'b1, 4'd5},
    {1'b0, 4'd1, 2'd2, 1'b1, 4'd4},   // R4: open after 4 closed cycles
    {1'b0, 4'd1, 2'd1, 1'b1, 4'd7},   // R7: straddling trigger
    {1'b0, 4'd3, 2'd1, 1'b1, 4'd3},
    {1'b0, 4'd1, 2'd2, 1'b1, 4'd4},
    {1'b1, 4'd1, 2'd2, 1'b1, 4'd5},
    {1'b1, 4'd1, 2'd2, 1'b1, 4'd5},   // R5: high, not falling
    {1'b0, 4'd1, 2'd2, 1'b1, 4'd5},
    {1'b0, 4'd1, 2'd1, 1'b1, 4'd6},   // R6: trigger on last open cycle
    {1'b0, 4'd3, 2'd1, 1'b1, 4'd3},
    {1'b0, 4'd1, 2'd2, 1'b1, 4'd4},
    {1'b0, 4'd3, 2'd2, 1'b1, 4'd4},
    {1'b0, 4'd1, 2'd0, 1'b0, 4'd9},   // R9: open expired
    {1'b0, 4'd5, 2'd0, 1'b0, 4'd10},
    {1'b0, 4'd1, 2'd1, 1'b1, 4'd10},  // R10: reset lasted 6 cycles
    {1'b1, 4'd2, 2'd1, 1'b1, 4'd3},
    {1'b0, 4'd1, 2'd1, 1'b1, 4'd3},
    {1'b0, 4'd1, 2'd3, 1'b1, 4'd8},   // R8: pretrigger
    {1'b1, 4'd2, 2'd3, 1'b1, 4'd8},
    {1'b0, 4'd1, 2'd3, 1'b1, 4'd8},
    {1'b0, 4'd1, 2'd0, 1'b0, 4'd8},   // R8: reset 8 cycles after closed start
    {1'b0, 4'd5, 2'd0, 1'b0, 4'd10},
    {1'b0, 4'd1, 2'd1, 1'b1, 4'd10},
    {1'b0, 4'd3, 2'd1, 1'b1, 4'd3},
    {1'b0, 4'd1, 2'd2, 1'b1, 4'd4},
    {1'b1, 4'd1, 2'd2, 1'b1, 4'd12},  // R12: single high sample
    {1'b0, 4'd2, 2'd2, 1'b1, 4'd12},
    {1'b0, 4'd1, 2'd0, 1'b0, 4'd12}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] exp_st, input logic exp_rst);
    total++;
    if (win_state !== exp_st || wd_rst_n !== exp_rst) begin
      bad++;
      $display("FAIL %s: state=%0d rst=%0b expected state=%0d rst=%0b",
               req, win_state, wd_rst_n, exp_st, exp_rst);
    end
  endtask

  task automatic steps(input logic pin, input int n);
    trig_in = pin;
    repeat (n * DIV) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad = 0;
    rst_n = 1'b0;
    pwr_good = 1'b1;
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", 2'd0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      steps(VEC[i][11], int'(VEC[i][10:7]));
      check(req_name(VEC[i][3:0]), VEC[i][6:5], VEC[i][4]);
    end

    // R10: failure reset ends after 6 cycles
    steps(1'b0, 5);
    check("R10", 2'd0, 1'b0);
    steps(1'b0, 1);
    check("R10", 2'd1, 1'b1);
    steps(1'b1, 2);

    // R11: power-good drop forces reset on the next clock
    pwr_good = 1'b0;
    @(negedge clk);
    check("R11", 2'd0, 1'b0);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", 2'd0, 1'b0);
    pwr_good = 1'b1;
    steps(1'b0, 5);
    check("R11", 2'd0, 1'b0);
    steps(1'b0, 1);
    check("R11", 2'd1, 1'b1);

    // R2: asynchronous reset acts without a clock edge
    steps(1'b0, 1);
    #3;
    rst_n = 1'b0;
    #1;
    check("R2", 2'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    steps(1'b0, 5);
    check("R2", 2'd0, 1'b0);
    steps(1'b0, 1);
    check("R3", 2'd1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule